// File: doc/BRIEF.md
# Accumulator Arithmetic and Rotate Unit

This block is the combinational core that an 8-bit processor datapath uses for every instruction that reads or changes the accumulator together with the carry flag. It takes the accumulator, a second operand byte, the current carry and a 4-bit operation code. It returns the new accumulator value, a write strobe for the accumulator register and the next carry.

The lower half of the code space holds the eight two-operand operations. Their 3-bit field is decoded in the same way whether the operand comes from a register or from an immediate byte. The choice of operand source is made upstream. The upper half holds the single-operand accumulator operations: four rotates, complement, and the two carry-only operations. No zero, sign, parity, overflow, half-carry or decimal-adjust flag is produced.

The unit has no clock and no state. Its outputs settle in the same cycle the inputs are applied. Because the unit is a pure function, there is no data stream and no back-pressure.

Top module: `acc_alu`

## Requirements
- R1: Codes 4'b0000 (add) and 4'b0001 (add with carry) give `{carry_o, result_o} = acc_i + opnd_i`, plus `carry_i` for code 0001. `acc_we_o` is 1.
- R2: Codes 4'b0010 (subtract) and 4'b0011 (subtract with borrow) give `result_o = acc_i - opnd_i` modulo 256, minus `carry_i` for code 0011. `carry_o` is 1 exactly when the true difference is negative. `acc_we_o` is 1.
- R3: Codes 4'b0100 (and), 4'b0101 (xor) and 4'b0110 (or) give the bitwise function of `acc_i` and `opnd_i`. `carry_o` is 0 and `acc_we_o` is 1.
- R4: Code 4'b0111 (compare) sets `carry_o` as the subtract of R2 would. `acc_we_o` is 0 and `result_o` equals `acc_i`.
- R5: Code 4'b1000 (rotate left circular) moves bits 6..0 up one place. Old bit 7 goes to bit 0 and to `carry_o`.
- R6: Code 4'b1001 (rotate right circular) moves bits 7..1 down one place. Old bit 0 goes to bit 7 and to `carry_o`.
- R7: Code 4'b1010 (rotate left through carry) moves `carry_i` into bit 0 and old bit 7 into `carry_o`.
- R8: Code 4'b1011 (rotate right through carry) moves `carry_i` into bit 7 and old bit 0 into `carry_o`.
- R9: Code 4'b1100 (complement) gives `result_o = ~acc_i` with `acc_we_o` 1. `carry_o` equals `carry_i`.
- R10: Code 4'b1101 forces `carry_o` to 1 and code 4'b1110 gives `carry_o = ~carry_i`. For both, `acc_we_o` is 0 and `result_o` equals `acc_i`.
- R11: Code 4'b1111 is reserved and has no effect: `acc_we_o` is 0, `result_o` equals `acc_i`, and `carry_o` equals `carry_i`.
- R12: `acc_we_o` is 0 for codes 0111, 1101, 1110 and 1111 only. Whenever it is 0, `result_o` equals `acc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand (register or immediate, chosen upstream) |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| result_o | output | 8 | Value to load into the accumulator |
| acc_we_o | output | 1 | Accumulator write strobe |
| carry_o | output | 1 | Next carry flag |

## Verification
Several rules are checked by the assertions whenever the inputs change:
- the write-strobe pattern per code,
- the rule that a suppressed write passes the accumulator through,
- the cleared carry of the logic operations,
- the carry behaviour of complement, the carry-only codes and the reserved code.

The arithmetic values themselves can only be shown by the bench's sweeps against its own reference. These include borrow polarity at the zero crossing, carry and borrow chaining, and the bit that each rotate moves in or out. The sweeps take every accumulator value with both carry states, against a set of operand bytes around the carry boundaries.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'b0000,
    OP_ADC  = 4'b0001,
    OP_SUB  = 4'b0010,
    OP_SBC  = 4'b0011,
    OP_AND  = 4'b0100,
    OP_XOR  = 4'b0101,
    OP_OR   = 4'b0110,
    OP_CMP  = 4'b0111,
    OP_RLC  = 4'b1000,
    OP_RRC  = 4'b1001,
    OP_RL   = 4'b1010,
    OP_RR   = 4'b1011,
    OP_CPL  = 4'b1100,
    OP_SCF  = 4'b1101,
    OP_CCF  = 4'b1110,
    OP_RSVD = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] {
    LU_AND = 2'd0,
    LU_XOR = 2'd1,
    LU_OR  = 2'd2,
    LU_INV = 2'd3
  } lu_fn_e;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             use_cin_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int EXT_W = WIDTH + 1;

  logic             cin_eff;
  logic [WIDTH-1:0] b_eff;
  logic             lsb_in;
  logic [EXT_W-1:0] total;

  always_comb begin
    cin_eff = use_cin_i & cin_i;
    b_eff   = sub_i ? ~b_i : b_i;
    // In two's-complement subtraction the incoming borrow lowers the +1.
    lsb_in  = sub_i ? ~cin_eff : cin_eff;
    total   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, lsb_in};
    sum_o   = total[WIDTH-1:0];
    cout_o  = sub_i ? ~total[WIDTH] : total[WIDTH];
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  lu_fn_e           fn_i,
  output logic [WIDTH-1:0] y_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      unique case (fn_i)
        LU_AND:  y_o[i] = a_i[i] & b_i[i];
        LU_XOR:  y_o[i] = a_i[i] ^ b_i[i];
        LU_OR:   y_o[i] = a_i[i] | b_i[i];
        default: y_o[i] = ~a_i[i];
      endcase
    end
  end

endmodule

// File: rtl/acc_alu_rotate.sv
module acc_alu_rotate #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             cin_i,
  input  logic             right_i,
  input  logic             thru_i,
  output logic [WIDTH-1:0] y_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  logic fill_left;
  logic fill_right;

  always_comb begin
    // Bit entering the vacated end: the carry when rotating through it,
    // otherwise the bit leaving at the opposite end.
    fill_left  = thru_i ? cin_i : a_i[MSB];
    fill_right = thru_i ? cin_i : a_i[0];
    if (right_i) begin
      y_o    = {fill_right, a_i[MSB:1]};
      cout_o = a_i[0];
    end else begin
      y_o    = {a_i[MSB-1:0], fill_left};
      cout_o = a_i[MSB];
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] opnd_i,
  input  logic             carry_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             acc_we_o,
  output logic             carry_o
);

  alu_op_e          op;
  logic             grp_arith;
  logic [2:0]       grp_fn;

  logic             as_sub;
  logic             as_use_cin;
  logic [WIDTH-1:0] as_sum;
  logic             as_cout;

  lu_fn_e           lu_fn;
  logic [WIDTH-1:0] lu_y;

  logic [WIDTH-1:0] rot_y;
  logic             rot_cout;

  assign op        = alu_op_e'(op_i);
  assign grp_arith = ~op_i[3];
  assign grp_fn    = op_i[2:0];

  // Adder/subtractor control: fn bit 1 selects subtract (also compare),
  // fn bit 0 selects carry chaining except for compare.
  assign as_sub     = grp_fn[1] | (grp_fn == 3'b111);
  assign as_use_cin = grp_fn[0] & ~grp_fn[2];

  acc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i       (acc_i),
    .b_i       (opnd_i),
    .cin_i     (carry_i),
    .use_cin_i (as_use_cin),
    .sub_i     (as_sub),
    .sum_o     (as_sum),
    .cout_o    (as_cout)
  );

  always_comb begin
    unique case (grp_fn[1:0])
      2'b00:   lu_fn = LU_AND;
      2'b01:   lu_fn = LU_XOR;
      2'b10:   lu_fn = LU_OR;
      default: lu_fn = LU_INV;
    endcase
    if (!grp_arith) lu_fn = LU_INV;
  end

  acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .fn_i (lu_fn),
    .y_o  (lu_y)
  );

  acc_alu_rotate #(.WIDTH(WIDTH)) u_rotate (
    .a_i     (acc_i),
    .cin_i   (carry_i),
    .right_i (op_i[0]),
    .thru_i  (op_i[1]),
    .y_o     (rot_y),
    .cout_o  (rot_cout)
  );

  always_comb begin
    result_o = acc_i;
    acc_we_o = 1'b0;
    carry_o  = carry_i;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        result_o = as_sum;
        acc_we_o = 1'b1;
        carry_o  = as_cout;
      end
      OP_AND, OP_XOR, OP_OR: begin
        result_o = lu_y;
        acc_we_o = 1'b1;
        carry_o  = 1'b0;
      end
      OP_CMP: begin
        carry_o  = as_cout;
      end
      OP_RLC, OP_RRC, OP_RL, OP_RR: begin
        result_o = rot_y;
        acc_we_o = 1'b1;
        carry_o  = rot_cout;
      end
      OP_CPL: begin
        result_o = lu_y;
        acc_we_o = 1'b1;
      end
      OP_SCF: carry_o = 1'b1;
      OP_CCF: carry_o = ~carry_i;
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] acc_i,
  input logic [WIDTH-1:0] opnd_i,
  input logic             carry_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             acc_we_o,
  input logic             carry_o
);
  logic no_write_code;
  assign no_write_code = (op_i == 4'b0111) || (op_i == 4'b1101) ||
                         (op_i == 4'b1110) || (op_i == 4'b1111);

  always_comb begin
    AST_WE_PATTERN: assert (acc_we_o == !no_write_code); // R12
    if (!acc_we_o) begin
      AST_NOWRITE_PASSES_ACC: assert (result_o == acc_i); // R12
    end
    if (op_i == 4'b0111) begin
      AST_CMP_NO_WRITE: assert (!acc_we_o); // R4
    end
    if (op_i == 4'b0100 || op_i == 4'b0101 || op_i == 4'b0110) begin
      AST_LOGIC_CARRY_CLEAR: assert (!carry_o); // R3
    end
    if (op_i == 4'b1100) begin
      AST_CPL_CARRY_KEPT: assert (carry_o == carry_i); // R9
    end
    if (op_i == 4'b1101) begin
      AST_SET_CARRY: assert (carry_o); // R10
    end
    if (op_i == 4'b1110) begin
      AST_FLIP_CARRY: assert (carry_o != carry_i); // R10
    end
    if (op_i == 4'b1111) begin
      AST_RESERVED_IDLE: assert (carry_o == carry_i && result_o == acc_i); // R11
    end
  end

endmodule

bind acc_alu acc_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .acc_i    (acc_i),
  .opnd_i   (opnd_i),
  .carry_i  (carry_i),
  .op_i     (op_i),
  .result_o (result_o),
  .acc_we_o (acc_we_o),
  .carry_o  (carry_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] acc_i = '0;
  logic [W-1:0] opnd_i = '0;
  logic         carry_i = 1'b0;
  logic [3:0]   op_i = '0;
  logic [W-1:0] result_o;
  logic         acc_we_o;
  logic         carry_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_alu #(.WIDTH(W)) u_dut (
    .acc_i    (acc_i),
    .opnd_i   (opnd_i),
    .carry_i  (carry_i),
    .op_i     (op_i),
    .result_o (result_o),
    .acc_we_o (acc_we_o),
    .carry_o  (carry_o)
  );

  function automatic string req_of(input int op);
    case (op)
      0, 1:    return "R1";
      2, 3:    return "R2";
      4, 5, 6: return "R3";
      7:       return "R4";
      8:       return "R5";
      9:       return "R6";
      10:      return "R7";
      11:      return "R8";
      12:      return "R9";
      13, 14:  return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic int opnd_pick(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'h01;
      2: return 8'h0F;
      3: return 8'h10;
      4: return 8'h7F;
      5: return 8'h80;
      6: return 8'hFE;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check_vec(input int op, input int a, input int b, input int c);
    int d;
    int er;
    int ew;
    int ec;
    er = a; ew = 1; ec = c;
    case (op)
      0:  begin d = a + b;     er = d & 255; ec = (d > 255) ? 1 : 0; end
      1:  begin d = a + b + c; er = d & 255; ec = (d > 255) ? 1 : 0; end
      2:  begin d = a - b;     er = d & 255; ec = (d < 0) ? 1 : 0; end
      3:  begin d = a - b - c; er = d & 255; ec = (d < 0) ? 1 : 0; end
      4:  begin er = a & b; ec = 0; end
      5:  begin er = a ^ b; ec = 0; end
      6:  begin er = a | b; ec = 0; end
      7:  begin d = a - b; ew = 0; ec = (d < 0) ? 1 : 0; end
      8:  begin er = ((a << 1) | (a >> 7)) & 255; ec = a >> 7; end
      9:  begin er = (a >> 1) | ((a & 1) << 7); ec = a & 1; end
      10: begin er = ((a << 1) | c) & 255; ec = a >> 7; end
      11: begin er = (a >> 1) | (c << 7); ec = a & 1; end
      12: begin er = (~a) & 255; end
      13: begin ew = 0; ec = 1; end
      14: begin ew = 0; ec = 1 - c; end
      default: begin ew = 0; end
    endcase
    checks++;
    if (int'(result_o) != er || int'(acc_we_o) != ew || int'(carry_o) != ec) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h c=%0d: got res=%02h we=%0d cy=%0d exp res=%02h we=%0d cy=%0d",
               req_of(op), op, a, b, c, result_o, acc_we_o, carry_o, er, ew, ec);
      if (ew == 0 && acc_we_o) $display("FAIL R12 write strobe high on no-write code %0d: got 1 expected 0", op);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state: all-zero inputs select add of zeros (R1).
    checks++;
    if (result_o != '0 || !acc_we_o || carry_o) begin
      errors++;
      $display("FAIL R1 reset state: got res=%02h we=%0d cy=%0d expected 00 1 0", result_o, acc_we_o, carry_o);
    end
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 8; k++) begin
        for (int a = 0; a < 256; a++) begin
          for (int c = 0; c < 2; c++) begin
            @(posedge clk);
            op_i    = op[3:0];
            acc_i   = a[7:0];
            opnd_i  = opnd_pick(k)[7:0];
            carry_i = c[0];
            @(negedge clk);
            check_vec(op, a, opnd_pick(k), c);
          end
        end
      end
    end
    finish_run();
  end

endmodule